// File: doc/BRIEF.md
# Transform Coefficient Quantizer

This block turns a stream of signed 12-bit transform coefficients, arriving one per valid cycle in 8×8 sub-block order, into 8-bit quantized levels. For ordinary coefficients, the divisor is twice a 5-bit step code supplied by the host. The DC coefficient of every sub-block in an intra-coded macroblock ignores the step code and is instead divided by 8 with rounding. All results are saturated into the 8-bit code space rather than allowed to wrap.

The host keeps its step registers static or changes them at any time. The block copies the step settings, the dual-step select and the intra flag only on the first coefficient of each macroblock. A change the host makes while a macroblock is being coded therefore takes effect at the next macroblock. In dual-step mode, intra macroblocks use a second step code and inter macroblocks use the first. Otherwise both kinds use the first.

Every coefficient passes through a fixed two-stage pipeline. Output valid and first-of-block leave the pipeline in step with the level that belongs to them.

Top module: `coef_quantizer`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `outValid`, `outFirst` and `outLevel` are all zero.
- R2: A coefficient sampled with `inValid` high at clock edge N appears at edge N+2. `outValid` equals `inValid` and `outFirst` equals `inValid && inFirst` from two edges earlier, and `outFirst` is never high without `outValid`.
- R3: A non-DC coefficient c produces the level trunc(|c| / (2·s)) carrying the sign of c, where s is the step code in use. The level is given as 8-bit two's complement, and truncation is toward zero.
- R4: Non-DC levels saturate to −127..+127, coded 0x81..0x7F. The code 0x80 never appears on a valid output.
- R5: A step code of 0 is treated as step 1, which gives a divisor of 2.
- R6: The step codes, the dual-step select and the intra flag are sampled only on a valid cycle with `inMbStart` high. That cycle's own coefficient already uses the newly sampled values. Changes on these inputs at any other time have no effect until the next macroblock start.
- R7: With `hostDual` latched as 1, intra macroblocks use `hostStepB` and inter macroblocks use `hostStepA`. With `hostDual` latched as 0, both kinds use `hostStepA`.
- R8: In an intra macroblock, each coefficient flagged by `inFirst` is a DC term. Its level is floor((c + 4) / 8), whatever the step code, and it is output as an unsigned 8-bit code.
- R9: The intra DC code is clamped to 1..254, and a rounded result of exactly 128 is sent as code 255.
- R10: In an inter macroblock, the coefficient flagged by `inFirst` is quantized by the step divisor, like any other coefficient.
- R11: While `outValid` is low, `outLevel` holds the last level that was output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Coefficient present on `inCoef` this cycle |
| inFirst | input | 1 | Coefficient is the first (DC) term of its sub-block |
| inMbStart | input | 1 | Coefficient is the first of a macroblock; latches the host settings |
| inIntra | input | 1 | Macroblock is intra coded (sampled at macroblock start) |
| inCoef | input | 12 | Signed transform coefficient |
| hostDual | input | 1 | 1 selects separate inter and intra step codes |
| hostStepA | input | 5 | Step code for inter macroblocks, or for all macroblocks in single mode |
| hostStepB | input | 5 | Step code for intra macroblocks in dual mode |
| outValid | output | 1 | Level present on `outLevel` |
| outFirst | output | 1 | Level belongs to the first coefficient of a sub-block |
| outLevel | output | 8 | Quantized level: two's complement, or an unsigned DC code |

## Verification
The bound checker watches every cycle for several things: the two-cycle alignment of valid and first-of-block, the absence of code 0x80, the holding of the level between valid outputs, and the quiet state at reset release. The bench's scenarios are the only way to show the arithmetic. This covers truncation and saturation against a reference divider, the rounding and clamping of the intra DC term including the 128-to-255 escape, and the treatment of step code zero. The scenarios also show that host settings changed in the middle of a macroblock take effect only at the next macroblock start, and that the dual-step select steers intra and inter macroblocks.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int COEF_W     = 12;
  localparam int STEP_W     = 5;
  localparam int LVL_W      = 8;
  localparam int DIV_W      = STEP_W + 1;
  localparam int DC_SHIFT   = 3;
  localparam int DC_BIAS    = 1 << (DC_SHIFT - 1);
  localparam int LVL_MAX    = (1 << (LVL_W - 1)) - 1;
  localparam int DC_MIN     = 1;
  localparam int DC_MAX     = (1 << LVL_W) - 2;
  localparam int DC_ESC_IN  = 1 << (LVL_W - 1);
  localparam int DC_ESC_OUT = (1 << LVL_W) - 1;

  typedef struct packed {
    logic             fire;
    logic             first;
    logic             dcSel;
    logic [DIV_W-1:0] divisor;
  } cq_strobe_t;
endpackage

// File: rtl/cq_ctrl.sv
module cq_ctrl
  import cq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              inFirst,
  input  logic              inMbStart,
  input  logic              inIntra,
  input  logic              hostDual,
  input  logic [STEP_W-1:0] hostStepA,
  input  logic [STEP_W-1:0] hostStepB,
  output cq_strobe_t        strobe
);
  logic              heldDual, heldIntra;
  logic [STEP_W-1:0] heldStepA, heldStepB;
  logic              latchNow;
  logic              effDual, effIntra;
  logic [STEP_W-1:0] effStepA, effStepB, stepSel, stepUse;

  assign latchNow = inValid & inMbStart;

  // settings copied at the macroblock boundary (R6)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldDual  <= 1'b0;
      heldIntra <= 1'b0;
      heldStepA <= '0;
      heldStepB <= '0;
    end else if (latchNow) begin
      heldDual  <= hostDual;
      heldIntra <= inIntra;
      heldStepA <= hostStepA;
      heldStepB <= hostStepB;
    end
  end

  always_comb begin
    effDual  = latchNow ? hostDual  : heldDual;
    effIntra = latchNow ? inIntra   : heldIntra;
    effStepA = latchNow ? hostStepA : heldStepA;
    effStepB = latchNow ? hostStepB : heldStepB;
    stepSel  = (effDual && effIntra) ? effStepB : effStepA;   // R7
    stepUse  = (stepSel == '0) ? STEP_W'(1) : stepSel;        // R5
    strobe.fire    = inValid;
    strobe.first   = inFirst;
    strobe.dcSel   = inFirst & effIntra;                      // R8, R10
    strobe.divisor = {stepUse, 1'b0};
  end
endmodule

// File: rtl/cq_datapath.sv
module cq_datapath
  import cq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  cq_strobe_t               strobe,
  input  logic signed [COEF_W-1:0] coef,
  output logic                     outValid,
  output logic                     outFirst,
  output logic [LVL_W-1:0]         outLevel
);
  localparam logic signed [COEF_W:0] DC_LO  = (COEF_W+1)'(DC_MIN);
  localparam logic signed [COEF_W:0] DC_HI  = (COEF_W+1)'(DC_MAX);
  localparam logic signed [COEF_W:0] DC_ESC = (COEF_W+1)'(DC_ESC_IN);

  cq_strobe_t               s1Strobe;
  logic signed [COEF_W-1:0] s1Coef;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Strobe <= '0;
      s1Coef   <= '0;
    end else begin
      s1Strobe <= strobe;
      if (strobe.fire) s1Coef <= coef;
    end
  end

  // magnitude and sign of the captured coefficient
  logic              negIn;
  logic [COEF_W-1:0] mag;
  assign negIn = s1Coef[COEF_W-1];
  assign mag   = negIn ? $unsigned(-s1Coef) : $unsigned(s1Coef);

  // unrolled restoring divider, one quotient bit per row
  logic [DIV_W-1:0]  rem [COEF_W];
  logic [COEF_W-1:0] quo;
  assign rem[0] = '0;

  for (genvar i = 0; i < COEF_W; i++) begin : g_row
    logic [DIV_W:0] trial;
    logic           take;
    assign trial = {rem[i], mag[COEF_W-1-i]};
    assign take  = trial >= {1'b0, s1Strobe.divisor};
    assign quo[COEF_W-1-i] = take;
    if (i < COEF_W - 1) begin : g_rem
      assign rem[i+1] = take ? (trial[DIV_W-1:0] - s1Strobe.divisor)
                             : trial[DIV_W-1:0];
    end
  end

  // step path: saturate magnitude then restore sign (R3, R4)
  logic [LVL_W-1:0] magSat, acLevel;
  always_comb begin
    if (quo > COEF_W'(LVL_MAX)) magSat = LVL_W'(LVL_MAX);
    else                        magSat = quo[LVL_W-1:0];
    acLevel = negIn ? (~magSat + 1'b1) : magSat;
  end

  // fixed intra DC path: round, clamp, escape (R8, R9)
  logic signed [COEF_W:0] dcSum, dcRound;
  logic [LVL_W-1:0]       dcLevel;
  always_comb begin
    dcSum   = $signed((COEF_W+1)'(s1Coef)) + $signed((COEF_W+1)'(DC_BIAS));
    dcRound = dcSum >>> DC_SHIFT;
    if (dcRound < DC_LO)        dcLevel = LVL_W'(DC_MIN);
    else if (dcRound > DC_HI)   dcLevel = LVL_W'(DC_MAX);
    else if (dcRound == DC_ESC) dcLevel = LVL_W'(DC_ESC_OUT);
    else                        dcLevel = dcRound[LVL_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outFirst <= 1'b0;
      outLevel <= '0;
    end else begin
      outValid <= s1Strobe.fire;
      outFirst <= s1Strobe.fire & s1Strobe.first;
      if (s1Strobe.fire) outLevel <= s1Strobe.dcSel ? dcLevel : acLevel;
    end
  end
endmodule

// File: rtl/coef_quantizer.sv
module coef_quantizer
  import cq_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     inValid,
  input  logic                     inFirst,
  input  logic                     inMbStart,
  input  logic                     inIntra,
  input  logic signed [COEF_W-1:0] inCoef,
  input  logic                     hostDual,
  input  logic [STEP_W-1:0]        hostStepA,
  input  logic [STEP_W-1:0]        hostStepB,
  output logic                     outValid,
  output logic                     outFirst,
  output logic [LVL_W-1:0]         outLevel
);
  cq_strobe_t strobe;

  cq_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .inValid   (inValid),
    .inFirst   (inFirst),
    .inMbStart (inMbStart),
    .inIntra   (inIntra),
    .hostDual  (hostDual),
    .hostStepA (hostStepA),
    .hostStepB (hostStepB),
    .strobe    (strobe)
  );

  cq_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .coef     (inCoef),
    .outValid (outValid),
    .outFirst (outFirst),
    .outLevel (outLevel)
  );
endmodule

// File: rtl/cq_checker.sv
module cq_checker
  import cq_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inFirst,
  input logic             outValid,
  input logic             outFirst,
  input logic [LVL_W-1:0] outLevel
);
  logic [1:0] sinceRst;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              sinceRst <= '0;
    else if (sinceRst != 2) sinceRst <= sinceRst + 2'd1;
  end

  p_quiet_release_r1: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 0) |-> (!outValid && !outFirst && outLevel == '0));

  p_valid_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2) |-> (outValid == $past(inValid, 2)));

  p_first_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2) |-> (outFirst == $past(inValid && inFirst, 2)));

  p_first_needs_valid_r2: assert property (@(posedge clk) disable iff (!rstN)
    outFirst |-> outValid);

  p_no_minus128_r4: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (outLevel != LVL_W'(1 << (LVL_W - 1))));

  p_level_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst != 0 && !outValid) |-> $stable(outLevel));
endmodule

bind coef_quantizer cq_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inFirst  (inFirst),
  .outValid (outValid),
  .outFirst (outFirst),
  .outLevel (outLevel)
);

// File: tb/coef_quantizer_bench.sv
`timescale 1ns/1ps
module coef_quantizer_bench;
  import cq_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic                     inValid = 0, inFirst = 0, inMbStart = 0, inIntra = 0;
  logic signed [COEF_W-1:0] inCoef = '0;
  logic                     hostDual = 0;
  logic [STEP_W-1:0]        hostStepA = '0, hostStepB = '0;
  logic                     outValid, outFirst;
  logic [LVL_W-1:0]         outLevel;

  coef_quantizer u_coef_quantizer (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inFirst(inFirst),
    .inMbStart(inMbStart), .inIntra(inIntra), .inCoef(inCoef),
    .hostDual(hostDual), .hostStepA(hostStepA), .hostStepB(hostStepB),
    .outValid(outValid), .outFirst(outFirst), .outLevel(outLevel)
  );

  typedef struct {
    logic [LVL_W-1:0] lvl;
    logic             first;
    string            tag;
  } exp_t;

  exp_t sb[$];
  int   nChecks = 0, nFails = 0;
  bit   done = 0;
  int   mStepA = 0, mStepB = 0;
  bit   mDual = 0, mIntra = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // reference levels straight from the requirements
  function automatic logic [LVL_W-1:0] refLevel(input int c, input bit dc, input int step);
    int r, s, m, q, v;
    if (dc) begin                       // R8, R9
      r = (c + 4) >>> 3;
      if (r < 1)         r = 1;
      else if (r > 254)  r = 254;
      else if (r == 128) r = 255;
      return LVL_W'(r);
    end
    s = (step == 0) ? 1 : step;         // R5
    m = (c < 0) ? -c : c;
    q = m / (2 * s);                    // R3
    if (q > 127) q = 127;               // R4
    v = (c < 0) ? -q : q;
    return LVL_W'(v);
  endfunction

  task automatic sendCoef(input int c, input bit first, input bit mb, input string tag);
    exp_t e;
    int   st;
    if (mb) begin
      mStepA = int'(hostStepA); mStepB = int'(hostStepB);
      mDual = hostDual; mIntra = inIntra;
    end
    st      = (mDual && mIntra) ? mStepB : mStepA;
    e.lvl   = refLevel(c, first && mIntra, st);
    e.first = first;
    e.tag   = tag;
    sb.push_back(e);
    inValid = 1; inFirst = first; inMbStart = mb; inCoef = COEF_W'(c);
    @(negedge clk);
    inValid = 0; inFirst = 0; inMbStart = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    exp_t e;
    if (rstN && outValid) begin
      if (sb.size() == 0) begin
        check(0, "R2", "output with nothing pending", 1, 0);
      end else begin
        e = sb.pop_front();
        check(outLevel == e.lvl, e.tag, "level", int'(outLevel), int'(e.lvl));
        check(outFirst == e.first, e.tag, "first flag", int'(outFirst), int'(e.first));
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL R2 watchdog: actual 0 expected 1 completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [LVL_W-1:0] held;
    idle(3);
    // R1: reset state
    check(!outValid && !outFirst && outLevel == '0, "R1", "reset outputs",
          int'(outLevel), 0);
    rstN = 1;
    @(negedge clk);
    check(!outValid && outLevel == '0, "R1", "after release", int'(outValid), 0);

    // R2: two-edge latency
    hostStepA = 5'd5; inIntra = 0;
    sendCoef(50, 1, 1, "R2");
    check(outValid == 0, "R2", "valid one edge after input", int'(outValid), 0);
    @(negedge clk);
    check(outValid == 1 && outFirst == 1, "R2", "valid two edges after input",
          int'(outValid), 1);
    idle(3);

    // R3, R4, R10: inter macroblock, step 5
    sendCoef(100, 1, 1, "R10");
    sendCoef(-37, 0, 0, "R3");
    sendCoef(9, 0, 0, "R3");
    sendCoef(-9, 0, 0, "R3");
    sendCoef(2047, 0, 0, "R4");
    sendCoef(-2048, 0, 0, "R4");
    sendCoef(1279, 0, 0, "R4");
    // R5: step code zero
    hostStepA = 5'd0;
    sendCoef(7, 1, 1, "R5");
    sendCoef(-7, 0, 0, "R5");
    sendCoef(300, 0, 0, "R5");
    // largest step
    hostStepA = 5'd31;
    sendCoef(2047, 1, 1, "R3");
    sendCoef(-61, 0, 0, "R3");
    idle(4);

    // R6: mid-macroblock changes ignored
    hostStepA = 5'd4;
    sendCoef(160, 1, 1, "R6");
    hostStepA = 5'd9; inIntra = 1; hostDual = 1; hostStepB = 5'd1;
    sendCoef(160, 0, 0, "R6");
    sendCoef(800, 1, 0, "R6");
    hostDual = 0; inIntra = 0;
    sendCoef(160, 1, 1, "R6");
    idle(4);

    // R7: dual steps
    hostDual = 1; hostStepA = 5'd3; hostStepB = 5'd8;
    inIntra = 1;
    sendCoef(1000, 1, 1, "R8");
    sendCoef(160, 0, 0, "R7");
    inIntra = 0;
    sendCoef(160, 1, 1, "R7");
    sendCoef(-160, 0, 0, "R7");
    hostDual = 0; inIntra = 1;
    sendCoef(600, 1, 1, "R8");
    sendCoef(160, 0, 0, "R7");
    idle(4);

    // R8, R9: intra DC per sub-block, clamping and escape
    hostStepA = 5'd2; inIntra = 1;
    sendCoef(1020, 1, 1, "R9");
    sendCoef(40, 0, 0, "R8");
    sendCoef(1027, 1, 0, "R9");
    sendCoef(1019, 1, 0, "R9");
    sendCoef(0, 1, 0, "R9");
    sendCoef(4, 1, 0, "R9");
    sendCoef(2047, 1, 0, "R9");
    sendCoef(-50, 1, 0, "R9");
    sendCoef(1000, 1, 0, "R8");
    sendCoef(-40, 0, 0, "R8");

    // R11: level held while idle
    inIntra = 0; hostStepA = 5'd5;
    sendCoef(100, 1, 1, "R11");
    @(negedge clk);
    held = outLevel;
    idle(5);
    check(outValid == 0 && outLevel == held, "R11", "level held",
          int'(outLevel), int'(held));

    // mixed stream across macroblocks
    for (int mb = 0; mb < 12; mb++) begin
      hostStepA = STEP_W'($urandom_range(31));
      hostStepB = STEP_W'($urandom_range(31));
      hostDual  = 1'($urandom_range(1));
      inIntra   = 1'($urandom_range(1));
      for (int k = 0; k < 24; k++) begin
        sendCoef(int'($urandom_range(4095)) - 2048, (k % 8) == 0, k == 0,
                 inIntra ? "R8" : "R3");
        if ((k % 5) == 4) idle(1);
      end
    end
    idle(5);
    check(sb.size() == 0, "R2", "pending results drained", sb.size(), 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule